// File: doc/BRIEF.md
# Age-Ordered Store Buffer with Byte-Range Dependence Search

This block keeps the pending stores of an out-of-order core in the order they were issued. A store takes an entry at dispatch and receives an age tag. Its address with access size, and its data, are written into that entry later and in either order. Once the core commits a store, the store leaves the head of the buffer towards memory, one per cycle, whenever the memory port accepts a write. A misprediction rewinds the buffer: every entry from a given age tag onward is discarded in a single cycle.

Each load presents an effective address, an access size and its age, which is the tag the next store would have received when the load was dispatched. In the same cycle the block compares the load against all pending stores older than the load. It reports one of three outcomes: no dependence, forwarding of data from one store, or wait. A two-bit mode sets the policy for older stores whose address is not yet known. Under the conservative policy such a store forces a wait. Under the speculative policy it is ignored and the result is flagged as speculative. Under the strict-order policy the load simply waits until no older store remains in the buffer.

Top module: `store_order_buffer`

## Requirements
- R1: After reset the buffer is empty: `alloc_tag` is 0, `mem_wr_valid` is 0 and a load with any age reports result 0 (no dependence).
- R2: Allocation hands out consecutive age tags starting at `alloc_tag`. When DEPTH entries are held, `alloc_ok` is 0 and the tag does not advance, even in a cycle in which the head drains.
- R3: Size codes 0, 1 and 2 (and 3) mean 1, 2 and 4 bytes. A load depends on a store when the byte range [addr, addr+bytes) of one intersects that of the other. A load with no such older store reports result 0.
- R4: Only stores allocated before the load count (tag older than `ld_age`); younger stores never affect the result.
- R5: When several older stores overlap the load, the youngest of them decides the result.
- R6: Result 1 (forward) is given only when the chosen store's bytes include every load byte and its data is present. `ld_fwd_data` then holds the load bytes right-aligned, upper bytes zero. A partial overlap, or a store whose data is missing, gives result 2 (wait). `ld_fwd_data` is 0 whenever the result is not 1.
- R7: In mode 0 (conservative), any older store without an address gives result 2.
- R8: In mode 1 (speculative), older stores without an address are skipped and `ld_spec` is 1 if one was skipped. In every other mode, and when no such store exists, `ld_spec` is 0.
- R9: In mode 2 (strict order), the result is 2 if any older store remains, else 0; addresses are not examined.
- R10: When the head entry is committed and has both its address and its data, `mem_wr_valid` is 1 with that store's address, size and data. The head leaves on a cycle with `mem_wr_ready`, stores leave in allocation order, and the outputs hold steady while the port is not ready.
- R11: A flush with tag F removes every entry whose tag is F or younger in that cycle, and the next allocation receives tag F. `alloc_ok` is 0 during a flush cycle.
- R12: A drain at the head and an allocation at the tail in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Request a new store entry |
| alloc_ok | output | 1 | Allocation accepted this cycle |
| alloc_tag | output | TW | Age tag the next allocation receives |
| addr_wr_en | input | 1 | Write address and size into an entry |
| addr_wr_tag | input | TW | Tag of the entry receiving the address |
| addr_wr_addr | input | AW | Store byte address |
| addr_wr_size | input | 2 | Store size code |
| data_wr_en | input | 1 | Write store data into an entry |
| data_wr_tag | input | TW | Tag of the entry receiving the data |
| data_wr_data | input | 32 | Store data, byte 0 at the store address |
| commit_en | input | 1 | Mark an entry committed |
| commit_tag | input | TW | Tag of the committed entry |
| flush_en | input | 1 | Discard entries from `flush_age` onward |
| flush_age | input | TW | First tag discarded |
| ld_valid | input | 1 | A load is presented |
| ld_addr | input | AW | Load byte address |
| ld_size | input | 2 | Load size code |
| ld_age | input | TW | Load age (store tag current at its dispatch) |
| dep_mode | input | 2 | 0 conservative, 1 speculative, 2 strict order |
| ld_result | output | 2 | 0 none, 1 forward, 2 wait |
| ld_fwd_data | output | 32 | Forwarded load bytes |
| ld_spec | output | 1 | Result assumed unknown-address stores independent |
| mem_wr_valid | output | 1 | Head store ready for memory |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | AW | Address of the draining store |
| mem_wr_size | output | 2 | Size code of the draining store |
| mem_wr_data | output | 32 | Data of the draining store |

## Verification
Draining at the head and allocating at the tail can land on the same clock edge. The bench fills the buffer and raises both the memory ready and an allocation request together. It first judges that a full buffer refuses the request even though an entry is leaving. In the next cycle it judges that the pop and the allocation both happened, by the next memory address and the advanced tag. A flush raised together with an allocation request is treated the same way: the request must be refused and the tail must land on the flush tag.

// File: rtl/sbuf_pkg.sv
`timescale 1ns/1ps
package sbuf_pkg;

    localparam int unsigned MAX_BYTES = 4;
    localparam int unsigned WORD_W    = 8 * MAX_BYTES;

    typedef enum logic [1:0] {
        MODE_CONSERV = 2'd0,
        MODE_SPEC    = 2'd1,
        MODE_INORDER = 2'd2,
        MODE_RSVD    = 2'd3
    } dep_mode_e;

    typedef enum logic [1:0] {
        RES_NONE = 2'd0,
        RES_FWD  = 2'd1,
        RES_WAIT = 2'd2
    } dep_res_e;

    typedef struct packed {
        logic     hit;
        logic     any_older;
        logic     any_unknown;
    } scan_sum_t;

    function automatic int unsigned size_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 2;
            default: return 4;
        endcase
    endfunction

    function automatic logic spans_overlap(input int unsigned a, input int unsigned na,
                                           input int unsigned b, input int unsigned nb);
        return (a < b + nb) && (b < a + na);
    endfunction

    function automatic logic span_covers(input int unsigned outer_a, input int unsigned outer_n,
                                         input int unsigned inner_a, input int unsigned inner_n);
        return (outer_a <= inner_a) && (inner_a + inner_n <= outer_a + outer_n);
    endfunction

    function automatic logic [WORD_W-1:0] byte_mask(input int unsigned n);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < int'(MAX_BYTES); i++) begin
            if (i < int'(n)) m[8*i +: 8] = 8'hFF;
        end
        return m;
    endfunction

endpackage

// File: rtl/sb_ptr_ctl.sv
`timescale 1ns/1ps
module sb_ptr_ctl #(
    parameter int DEPTH = 8,
    parameter int TW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc_req,
    input  logic          pop,
    input  logic          flush_en,
    input  logic [TW-1:0] flush_age,
    output logic [TW-1:0] head,
    output logic [TW-1:0] tail,
    output logic          alloc_ok
);
    logic [TW-1:0] count;
    logic          full;

    assign count    = tail - head;
    assign full     = (count == TW'(DEPTH));
    assign alloc_ok = alloc_req && !full && !flush_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
            tail <= '0;
        end else begin
            if (pop) head <= head + 1'b1;
            if (flush_en)      tail <= flush_age;
            else if (alloc_ok) tail <= tail + 1'b1;
        end
    end

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (tail - head) <= TW'(DEPTH));

    assert_alloc_step_R2: assert property (@(posedge clk) disable iff (rst)
        alloc_ok |=> (tail == $past(tail) + 1'b1));

    assert_flush_rewind_R11: assert property (@(posedge clk) disable iff (rst)
        flush_en |=> (tail == $past(flush_age)));

endmodule

// File: rtl/sb_entries.sv
`timescale 1ns/1ps
module sb_entries
    import sbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 12,
    parameter int PW    = 3,
    parameter int TW    = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [TW-1:0]                  head,
    input  logic [TW-1:0]                  tail,
    input  logic                           alloc_ok,
    input  logic                           addr_wr_en,
    input  logic [TW-1:0]                  addr_wr_tag,
    input  logic [AW-1:0]                  addr_wr_addr,
    input  logic [1:0]                     addr_wr_size,
    input  logic                           data_wr_en,
    input  logic [TW-1:0]                  data_wr_tag,
    input  logic [WORD_W-1:0]              data_wr_data,
    input  logic                           commit_en,
    input  logic [TW-1:0]                  commit_tag,
    input  logic                           pop,
    input  logic                           flush_en,
    input  logic [TW-1:0]                  flush_age,
    output logic [DEPTH-1:0]               e_valid,
    output logic [DEPTH-1:0]               e_aok,
    output logic [DEPTH-1:0]               e_dok,
    output logic [DEPTH-1:0]               e_cmt,
    output logic [DEPTH-1:0][AW-1:0]       e_addr,
    output logic [DEPTH-1:0][1:0]          e_size,
    output logic [DEPTH-1:0][WORD_W-1:0]   e_data
);
    logic [TW-1:0] flush_off;
    assign flush_off = flush_age - head;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [PW-1:0]     rel;
        logic [TW-1:0]     my_tag;
        logic              take_alloc;
        logic              v_q, aok_q, dok_q, cmt_q;
        logic [AW-1:0]     addr_q;
        logic [1:0]        size_q;
        logic [WORD_W-1:0] data_q;

        assign rel        = PW'(i) - head[PW-1:0];
        assign my_tag     = head + {1'b0, rel};
        assign take_alloc = alloc_ok && (tail[PW-1:0] == PW'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q    <= 1'b0;
                aok_q  <= 1'b0;
                dok_q  <= 1'b0;
                cmt_q  <= 1'b0;
                addr_q <= '0;
                size_q <= '0;
                data_q <= '0;
            end else begin
                if (take_alloc) begin
                    v_q   <= 1'b1;
                    aok_q <= 1'b0;
                    dok_q <= 1'b0;
                    cmt_q <= 1'b0;
                end
                if (addr_wr_en && v_q && (addr_wr_tag == my_tag)) begin
                    aok_q  <= 1'b1;
                    addr_q <= addr_wr_addr;
                    size_q <= addr_wr_size;
                end
                if (data_wr_en && v_q && (data_wr_tag == my_tag)) begin
                    dok_q  <= 1'b1;
                    data_q <= data_wr_data;
                end
                if (commit_en && v_q && (commit_tag == my_tag)) cmt_q <= 1'b1;
                if (pop && (head[PW-1:0] == PW'(i)))            v_q   <= 1'b0;
                if (flush_en && v_q && ({1'b0, rel} >= flush_off)) v_q <= 1'b0;
            end
        end

        assign e_valid[i] = v_q;
        assign e_aok[i]   = aok_q;
        assign e_dok[i]   = dok_q;
        assign e_cmt[i]   = cmt_q;
        assign e_addr[i]  = addr_q;
        assign e_size[i]  = size_q;
        assign e_data[i]  = data_q;
    end

endmodule

// File: rtl/sb_search.sv
`timescale 1ns/1ps
module sb_search
    import sbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 12,
    parameter int PW    = 3,
    parameter int TW    = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [TW-1:0]                  head,
    input  logic [DEPTH-1:0]               e_valid,
    input  logic [DEPTH-1:0]               e_aok,
    input  logic [DEPTH-1:0]               e_dok,
    input  logic [DEPTH-1:0][AW-1:0]       e_addr,
    input  logic [DEPTH-1:0][1:0]          e_size,
    input  logic [DEPTH-1:0][WORD_W-1:0]   e_data,
    input  logic                           ld_valid,
    input  logic [AW-1:0]                  ld_addr,
    input  logic [1:0]                     ld_size,
    input  logic [TW-1:0]                  ld_age,
    input  logic [1:0]                     mode,
    output logic [1:0]                     res_kind,
    output logic [WORD_W-1:0]              res_data,
    output logic                           res_spec
);
    dep_mode_e     mode_e;
    logic [TW-1:0] ld_off;
    scan_sum_t     sum;
    logic [PW-1:0] hit_idx;
    logic [PW-1:0] idx_k;
    int unsigned   ld_a, ld_n, st_a, st_n;

    assign mode_e = dep_mode_e'(mode);
    assign ld_off = ld_age - head;
    assign ld_a   = 32'(ld_addr);
    assign ld_n   = size_bytes(ld_size);

    // Walk entries from oldest to youngest; a later match overrides an earlier one.
    always_comb begin
        sum     = '0;
        hit_idx = '0;
        idx_k   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx_k = head[PW-1:0] + PW'(k);
            if (e_valid[idx_k] && (TW'(k) < ld_off)) begin
                sum.any_older = 1'b1;
                if (!e_aok[idx_k]) begin
                    sum.any_unknown = 1'b1;
                end else if (spans_overlap(32'(e_addr[idx_k]), size_bytes(e_size[idx_k]), ld_a, ld_n)) begin
                    sum.hit = 1'b1;
                    hit_idx = idx_k;
                end
            end
        end
    end

    assign st_a = 32'(e_addr[hit_idx]);
    assign st_n = size_bytes(e_size[hit_idx]);

    always_comb begin
        res_kind = RES_NONE;
        res_data = '0;
        res_spec = 1'b0;
        if (ld_valid) begin
            if (mode_e == MODE_INORDER) begin
                res_kind = sum.any_older ? RES_WAIT : RES_NONE;
            end else begin
                if (mode_e != MODE_SPEC && sum.any_unknown) begin
                    res_kind = RES_WAIT;
                end else if (sum.hit) begin
                    if (span_covers(st_a, st_n, ld_a, ld_n) && e_dok[hit_idx]) begin
                        res_kind = RES_FWD;
                        res_data = (e_data[hit_idx] >> (8 * (ld_a - st_a))) & byte_mask(ld_n);
                    end else begin
                        res_kind = RES_WAIT;
                    end
                end
                res_spec = (mode_e == MODE_SPEC) && sum.any_unknown;
            end
        end
    end

    assert_inorder_no_fwd_R9: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && mode_e == MODE_INORDER) |-> (res_kind != RES_FWD));

    assert_spec_only_mode_R8: assert property (@(posedge clk) disable iff (rst)
        res_spec |-> (mode_e == MODE_SPEC));

    assert_idle_no_result_R3: assert property (@(posedge clk) disable iff (rst)
        !ld_valid |-> (res_kind == RES_NONE && res_data == '0));

endmodule

// File: rtl/store_order_buffer.sv
`timescale 1ns/1ps
module store_order_buffer
    import sbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 12,
    localparam int PW   = $clog2(DEPTH),
    localparam int TW   = PW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_req,
    output logic              alloc_ok,
    output logic [TW-1:0]     alloc_tag,
    input  logic              addr_wr_en,
    input  logic [TW-1:0]     addr_wr_tag,
    input  logic [AW-1:0]     addr_wr_addr,
    input  logic [1:0]        addr_wr_size,
    input  logic              data_wr_en,
    input  logic [TW-1:0]     data_wr_tag,
    input  logic [WORD_W-1:0] data_wr_data,
    input  logic              commit_en,
    input  logic [TW-1:0]     commit_tag,
    input  logic              flush_en,
    input  logic [TW-1:0]     flush_age,
    input  logic              ld_valid,
    input  logic [AW-1:0]     ld_addr,
    input  logic [1:0]        ld_size,
    input  logic [TW-1:0]     ld_age,
    input  logic [1:0]        dep_mode,
    output logic [1:0]        ld_result,
    output logic [WORD_W-1:0] ld_fwd_data,
    output logic              ld_spec,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [AW-1:0]     mem_wr_addr,
    output logic [1:0]        mem_wr_size,
    output logic [WORD_W-1:0] mem_wr_data
);
    logic [TW-1:0]                head, tail;
    logic                         pop;
    logic [PW-1:0]                hidx;
    logic [DEPTH-1:0]             e_valid, e_aok, e_dok, e_cmt;
    logic [DEPTH-1:0][AW-1:0]     e_addr;
    logic [DEPTH-1:0][1:0]        e_size;
    logic [DEPTH-1:0][WORD_W-1:0] e_data;

    sb_ptr_ctl #(.DEPTH(DEPTH), .TW(TW)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .alloc_req (alloc_req),
        .pop       (pop),
        .flush_en  (flush_en),
        .flush_age (flush_age),
        .head      (head),
        .tail      (tail),
        .alloc_ok  (alloc_ok)
    );

    sb_entries #(.DEPTH(DEPTH), .AW(AW), .PW(PW), .TW(TW)) u_ent (
        .clk          (clk),
        .rst          (rst),
        .head         (head),
        .tail         (tail),
        .alloc_ok     (alloc_ok),
        .addr_wr_en   (addr_wr_en),
        .addr_wr_tag  (addr_wr_tag),
        .addr_wr_addr (addr_wr_addr),
        .addr_wr_size (addr_wr_size),
        .data_wr_en   (data_wr_en),
        .data_wr_tag  (data_wr_tag),
        .data_wr_data (data_wr_data),
        .commit_en    (commit_en),
        .commit_tag   (commit_tag),
        .pop          (pop),
        .flush_en     (flush_en),
        .flush_age    (flush_age),
        .e_valid      (e_valid),
        .e_aok        (e_aok),
        .e_dok        (e_dok),
        .e_cmt        (e_cmt),
        .e_addr       (e_addr),
        .e_size       (e_size),
        .e_data       (e_data)
    );

    sb_search #(.DEPTH(DEPTH), .AW(AW), .PW(PW), .TW(TW)) u_srch (
        .clk      (clk),
        .rst      (rst),
        .head     (head),
        .e_valid  (e_valid),
        .e_aok    (e_aok),
        .e_dok    (e_dok),
        .e_addr   (e_addr),
        .e_size   (e_size),
        .e_data   (e_data),
        .ld_valid (ld_valid),
        .ld_addr  (ld_addr),
        .ld_size  (ld_size),
        .ld_age   (ld_age),
        .mode     (dep_mode),
        .res_kind (ld_result),
        .res_data (ld_fwd_data),
        .res_spec (ld_spec)
    );

    assign alloc_tag    = tail;
    assign hidx         = head[PW-1:0];
    assign mem_wr_valid = e_valid[hidx] && e_cmt[hidx] && e_aok[hidx] && e_dok[hidx];
    assign mem_wr_addr  = e_addr[hidx];
    assign mem_wr_size  = e_size[hidx];
    assign mem_wr_data  = e_data[hidx];
    assign pop          = mem_wr_valid && mem_wr_ready;

    assert_drain_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && !mem_wr_ready && !flush_en) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    assert_drain_advance_R10: assert property (@(posedge clk) disable iff (rst)
        pop |=> (head == $past(head) + 1'b1));

endmodule

// File: tb/store_order_buffer_test.sv
`timescale 1ns/1ps
module store_order_buffer_test;
    localparam int DEPTH = 8;
    localparam int AW    = 12;
    localparam int TW    = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst;
    logic          alloc_req, alloc_ok;
    logic [TW-1:0] alloc_tag;
    logic          addr_wr_en;
    logic [TW-1:0] addr_wr_tag;
    logic [AW-1:0] addr_wr_addr;
    logic [1:0]    addr_wr_size;
    logic          data_wr_en;
    logic [TW-1:0] data_wr_tag;
    logic [31:0]   data_wr_data;
    logic          commit_en;
    logic [TW-1:0] commit_tag;
    logic          flush_en;
    logic [TW-1:0] flush_age;
    logic          ld_valid;
    logic [AW-1:0] ld_addr;
    logic [1:0]    ld_size;
    logic [TW-1:0] ld_age;
    logic [1:0]    dep_mode;
    logic [1:0]    ld_result;
    logic [31:0]   ld_fwd_data;
    logic          ld_spec;
    logic          mem_wr_valid, mem_wr_ready;
    logic [AW-1:0] mem_wr_addr;
    logic [1:0]    mem_wr_size;
    logic [31:0]   mem_wr_data;

    store_order_buffer #(.DEPTH(DEPTH), .AW(AW)) uut (.*);

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mask_of(input int n);
        return (n >= 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * n)) - 32'h1);
    endfunction

    task automatic alloc(output logic [TW-1:0] t);
        @(negedge clk);
        t = alloc_tag;
        alloc_req = 1'b1;
        #1 chk("R2 alloc accepted", {31'd0, alloc_ok}, 32'd1);
        @(negedge clk);
        alloc_req = 1'b0;
    endtask

    task automatic put_addr(input logic [TW-1:0] t, input int a, input int sz);
        @(negedge clk);
        addr_wr_en = 1'b1; addr_wr_tag = t; addr_wr_addr = AW'(a); addr_wr_size = 2'(sz);
        @(negedge clk);
        addr_wr_en = 1'b0;
    endtask

    task automatic put_data(input logic [TW-1:0] t, input logic [31:0] d);
        @(negedge clk);
        data_wr_en = 1'b1; data_wr_tag = t; data_wr_data = d;
        @(negedge clk);
        data_wr_en = 1'b0;
    endtask

    task automatic do_commit(input logic [TW-1:0] t);
        @(negedge clk);
        commit_en = 1'b1; commit_tag = t;
        @(negedge clk);
        commit_en = 1'b0;
    endtask

    task automatic do_flush(input logic [TW-1:0] t);
        @(negedge clk);
        flush_en = 1'b1; flush_age = t;
        @(negedge clk);
        flush_en = 1'b0;
    endtask

    task automatic q(input int a, input int sz, input logic [TW-1:0] age, input int md);
        ld_valid = 1'b1; ld_addr = AW'(a); ld_size = 2'(sz); ld_age = age; dep_mode = 2'(md);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [TW-1:0] ta, tb, tx, ty, tz, tw, tnew;
        logic [TW-1:0] tf [DEPTH];
        logic [31:0]   dval;

        rst = 1'b1;
        alloc_req = 0; addr_wr_en = 0; addr_wr_tag = 0; addr_wr_addr = 0; addr_wr_size = 0;
        data_wr_en = 0; data_wr_tag = 0; data_wr_data = 0; commit_en = 0; commit_tag = 0;
        flush_en = 0; flush_age = 0; ld_valid = 0; ld_addr = 0; ld_size = 0; ld_age = 0;
        dep_mode = 0; mem_wr_ready = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 tag after reset", 32'(alloc_tag), 32'd0);
        chk("R1 drain idle", {31'd0, mem_wr_valid}, 32'd0);
        q(20, 2, 0, 2);
        chk("R1 empty result", 32'(ld_result), 32'd0);

        // R3 / R6 sweep of byte-range relations in conservative mode
        dval = 32'hD4C3_B2A1;
        for (int sa = 0; sa < 4; sa++) begin
            for (int ss = 0; ss < 3; ss++) begin
                alloc(ta);
                put_addr(ta, 16 + sa, ss);
                put_data(ta, dval);
                for (int la = 12; la < 24; la++) begin
                    for (int ls = 0; ls < 3; ls++) begin
                        int st, sb, lb, ek;
                        logic [31:0] ed;
                        st = 16 + sa; sb = 1 << ss; lb = 1 << ls;
                        ek = 0; ed = 32'd0;
                        if (la < st + sb && st < la + lb) begin
                            if (st <= la && la + lb <= st + sb) begin
                                ek = 1;
                                ed = (dval >> (8 * (la - st))) & mask_of(lb);
                            end else begin
                                ek = 2;
                            end
                        end
                        q(la, ls, ta + 1'b1, 0);
                        chk("R3 R6 sweep kind", 32'(ld_result), 32'(ek));
                        chk("R6 sweep data", ld_fwd_data, ed);
                    end
                end
                do_flush(ta);
            end
        end

        // R6 data missing then present
        alloc(ta);
        put_addr(ta, 40, 2);
        q(41, 1, ta + 1'b1, 0);
        chk("R6 data missing waits", 32'(ld_result), 32'd2);
        put_data(ta, 32'h1122_3344);
        q(41, 1, ta + 1'b1, 0);
        chk("R6 forward after data", 32'(ld_result), 32'd1);
        chk("R6 forward bytes", ld_fwd_data, 32'h0000_2233);
        do_flush(ta);

        // R4 / R5 ordering by age
        alloc(ta); alloc(tb);
        put_addr(ta, 64, 2); put_data(ta, 32'h0A0B_0C0D);
        put_addr(tb, 64, 2); put_data(tb, 32'h0102_0304);
        q(64, 2, ta, 0);
        chk("R4 no older store", 32'(ld_result), 32'd0);
        q(64, 2, tb, 0);
        chk("R4 younger ignored", ld_fwd_data, 32'h0A0B_0C0D);
        q(64, 2, tb + 1'b1, 0);
        chk("R5 youngest wins kind", 32'(ld_result), 32'd1);
        chk("R5 youngest wins data", ld_fwd_data, 32'h0102_0304);
        do_flush(ta);

        // R7 / R8 / R9 unknown-address policies
        alloc(ta); alloc(tb);
        put_addr(ta, 100, 0); put_data(ta, 32'h0000_00EE);
        q(200, 2, tb + 1'b1, 0);
        chk("R7 conservative waits", 32'(ld_result), 32'd2);
        chk("R8 no spec in mode 0", {31'd0, ld_spec}, 32'd0);
        q(200, 2, tb + 1'b1, 1);
        chk("R8 speculative none", 32'(ld_result), 32'd0);
        chk("R8 spec flag set", {31'd0, ld_spec}, 32'd1);
        q(100, 0, tb + 1'b1, 1);
        chk("R8 speculative forward", 32'(ld_result), 32'd1);
        chk("R8 speculative data", ld_fwd_data, 32'h0000_00EE);
        q(200, 2, tb, 1);
        chk("R8 spec clear without unknown", {31'd0, ld_spec}, 32'd0);
        q(200, 2, tb + 1'b1, 2);
        chk("R9 strict waits", 32'(ld_result), 32'd2);
        q(100, 0, ta, 2);
        chk("R9 strict none", 32'(ld_result), 32'd0);
        do_flush(ta);

        // R2 full buffer
        for (int i = 0; i < DEPTH; i++) alloc(tf[i]);
        @(negedge clk);
        alloc_req = 1'b1;
        #1 chk("R2 full refused", {31'd0, alloc_ok}, 32'd0);
        @(negedge clk);
        alloc_req = 1'b0;
        #1 chk("R2 tag held when full", 32'(alloc_tag), 32'(tf[DEPTH-1] + 1'b1));
        for (int i = 0; i < DEPTH; i++) begin
            put_addr(tf[i], 300 + 4 * i, 2);
            put_data(tf[i], 32'h100 + 32'(i));
            do_commit(tf[i]);
        end

        // R10 drain, R12 drain with allocation
        @(negedge clk);
        #1 chk("R10 head valid", {31'd0, mem_wr_valid}, 32'd1);
        chk("R10 head addr", 32'(mem_wr_addr), 32'd300);
        chk("R10 head data", mem_wr_data, 32'h100);
        @(negedge clk);
        #1 chk("R10 held while not ready", 32'(mem_wr_addr), 32'd300);
        @(negedge clk);
        mem_wr_ready = 1'b1; alloc_req = 1'b1;
        #1 chk("R2 full refused while draining", {31'd0, alloc_ok}, 32'd0);
        @(negedge clk);
        #1 chk("R12 first pop", 32'(mem_wr_addr), 32'd304);
        chk("R12 alloc accepted with drain", {31'd0, alloc_ok}, 32'd1);
        tnew = alloc_tag;
        @(negedge clk);
        alloc_req = 1'b0;
        #1 chk("R12 pop and alloc addr", 32'(mem_wr_addr), 32'd308);
        chk("R12 pop and alloc tag", 32'(alloc_tag), 32'(tnew + 1'b1));
        for (int k = 2; k < DEPTH; k++) begin
            chk("R10 drain order", 32'(mem_wr_addr), 32'(300 + 4 * k));
            chk("R10 drain size", 32'(mem_wr_size), 32'd2);
            @(negedge clk);
            #1;
        end
        chk("R10 stops at uncommitted", {31'd0, mem_wr_valid}, 32'd0);
        mem_wr_ready = 1'b0;
        do_flush(tnew);

        // R11 flush
        alloc(tx); alloc(ty); alloc(tz);
        put_addr(tx, 500, 2); put_data(tx, 32'h5000_0001);
        put_addr(ty, 500, 2); put_data(ty, 32'h5000_0002);
        put_addr(tz, 500, 2); put_data(tz, 32'h5000_0003);
        @(negedge clk);
        flush_en = 1'b1; flush_age = ty; alloc_req = 1'b1;
        #1 chk("R11 alloc refused in flush", {31'd0, alloc_ok}, 32'd0);
        @(negedge clk);
        flush_en = 1'b0; alloc_req = 1'b0;
        #1 chk("R11 tail rewound", 32'(alloc_tag), 32'(ty));
        q(500, 2, ty, 0);
        chk("R11 survivor forwards", ld_fwd_data, 32'h5000_0001);
        alloc(tw);
        chk("R11 reused tag", 32'(tw), 32'(ty));
        q(500, 2, tw + 1'b1, 0);
        chk("R11 flushed entry gone", 32'(ld_result), 32'd2);
        do_flush(tx);
        #1 chk("R11 empty after flush", 32'(alloc_tag), 32'(tx));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule